// File: doc/BRIEF.md
# Nibble-Port Dual-Read Flip-Flop RAM

This block is a small register-file memory built entirely from flip-flops. It holds 32 bytes arranged as two pages of sixteen bytes. It has two access ports. Port A can both read and write. Port B can only read. Each port moves one nibble (4 bits) at a time. A half-select input on each port picks either the low or the high nibble of the byte it addresses. Both ports read on every cycle, and neither has a read enable.

A few options are sampled from a configuration bus on the first clock edge after reset is released. These options are:
- the page that both ports can reach;
- whether each port's read data comes straight from the storage or passes through an output register;
- whether a port-A write is forwarded to the read outputs in the same cycle (write-through) or the outputs keep showing the stored value until the write lands (read-before-write).

Reset never touches the stored bytes. A host can reset the block with a different page option to reach the other half of the storage.

Top module: `nibram_top`

## Requirements
- R1: The storage is two pages of sixteen bytes. A port address `{page, addr[3:0]}` selects a byte. `half=0` selects bits [3:0] of that byte and `half=1` selects bits [7:4]. The page is the captured configuration bit 0.
- R2: With the port's register option clear, each port shows the addressed nibble combinationally, on every cycle, with no enable.
- R3: A clock edge with `a_we=1` (outside reset) writes `a_wdata` into the selected nibble only. The other nibble of that byte is unchanged.
- R4: Stored contents survive reset. Writes are ignored while `rst_n` is low and on the first edge after release.
- R5: Configuration is taken from `cfg_in` only on the first rising clock edge with `rst_n` high after it was low. Bits 1, 2, 3 and 7 have no effect. Later changes of `cfg_in` have no effect.
- R6: Configuration bit 4 registers port A. Read data then appears one clock after the address and holds until the next edge. The register reads zero after the release edge.
- R7: Configuration bit 5 does the same for port B.
- R8: With bit 6 set, a combinational port A shows `a_wdata` during a write cycle. With bit 6 clear, it shows the previously stored nibble.
- R9: A combinational port B whose address and half match a port-A write follows the bit-6 setting. A port B reading the other nibble of that byte keeps showing the stored value.
- R10: A registered port captures the forwarded write data when bit 6 is set, and the old stored nibble when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_in | input | 8 | Option bus sampled at reset release |
| a_addr | input | 4 | Port A byte address |
| a_half | input | 1 | Port A nibble select |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | 4 | Port A write nibble |
| b_addr | input | 4 | Port B byte address |
| b_half | input | 1 | Port B nibble select |
| a_rdata | output | 4 | Port A read nibble |
| b_rdata | output | 4 | Port B read nibble |

## Verification
A wrong stored nibble shows up on a combinational port within the same cycle in which it is addressed. On a registered port it shows up one edge later. A badly captured option shows up on the first access after release in one of three ways: the wrong page, an extra or missing cycle of latency, or a forwarded value where the old value was expected. Forwarding and latency faults can only be seen in a write cycle or on the edge right after it. The bench therefore samples both ports in that cycle and on that edge.

// File: rtl/nibram_pkg.sv
// Shared constants and types for the nibble-port flip-flop RAM.
// Assumes an 8-bit option bus with fixed bit meanings.
package nibram_pkg;
    localparam int CFG_W        = 8;
    localparam int PAGE_W       = 1;
    localparam int HALVES       = 2;
    localparam int CFG_PAGE_BIT = 0;
    localparam int CFG_REGA_BIT = 4;
    localparam int CFG_REGB_BIT = 5;
    localparam int CFG_FWD_BIT  = 6;

    typedef struct packed {
        logic fwd;
        logic reg_b;
        logic reg_a;
        logic page;
    } cfg_t;
endpackage

// File: rtl/nibram_cfg.sv
// Option capture: samples the option bus on the first edge after reset
// release and holds it otherwise, including while reset is low.
// Assumes rst_n is synchronous to clk.
module nibram_cfg
    import nibram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_in,
    output cfg_t             cfg_q,
    output logic             capture,
    output logic             run
);
    logic rst_seen;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_in[7], cfg_in[3:1]};

    // Track whether reset was released one edge ago.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b0;
        else        rst_seen <= 1'b1;
    end

    assign capture = rst_n & ~rst_seen;
    assign run     = rst_n &  rst_seen;

    // Load the options only at the release edge.
    always_ff @(posedge clk) begin
        if (capture) begin
            cfg_q.page  <= cfg_in[CFG_PAGE_BIT];
            cfg_q.reg_a <= cfg_in[CFG_REGA_BIT];
            cfg_q.reg_b <= cfg_in[CFG_REGB_BIT];
            cfg_q.fwd   <= cfg_in[CFG_FWD_BIT];
        end
    end
endmodule

// File: rtl/nibram_store.sv
// Flip-flop storage: ENTRIES bytes kept as HALVES nibbles each, one
// nibble write port and NRD combinational nibble read ports.
// Assumes no reset on the array so that contents survive reset.
module nibram_store #(
    parameter int ENTRIES = 32,
    parameter int DATA_W  = 4,
    parameter int HALVES  = 2,
    parameter int NRD     = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int HALF_W = $clog2(HALVES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [HALF_W-1:0] wr_half,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx  [NRD],
    input  logic [HALF_W-1:0] rd_half [NRD],
    output logic [DATA_W-1:0] rd_data [NRD]
);
    logic [DATA_W-1:0] mem [ENTRIES][HALVES];

    // Write the selected nibble; the other nibble keeps its value.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx][wr_half] <= wr_data;
    end

    // One combinational read mux per port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_idx[p]][rd_half[p]];
    end
endmodule

// File: rtl/nibram_rdport.sv
// Read-port output stage: optional forwarding of the write nibble and
// an optional output register that clears while the block is not running.
// Assumes hit is high only in a cycle where this port's nibble is written.
module nibram_rdport #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              live,
    input  logic              reg_en,
    input  logic              fwd_en,
    input  logic              hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] comb_data;
    logic [DATA_W-1:0] held;

    // Forward the write data only with forwarding on and a hit.
    assign comb_data = (fwd_en && hit) ? wr_data : mem_data;

    // Output register; cleared until the block runs.
    always_ff @(posedge clk) begin
        if (!live) held <= '0;
        else       held <= comb_data;
    end

    assign rdata = reg_en ? held : comb_data;
endmodule

// File: rtl/nibram_top.sv
// Top level of the nibble-port RAM: two pages of ADDR_W-addressed bytes,
// port A read/write, port B read-only, options captured at reset release.
// Assumes a synchronous active-low reset and a single clock.
module nibram_top
    import nibram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_in,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_half,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_half,
    output logic [DATA_W-1:0] a_rdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int NRD     = 2;
    localparam int IDX_W   = PAGE_W + ADDR_W;
    localparam int ENTRIES = 1 << IDX_W;

    cfg_t              cfg_q;
    logic              capture;
    logic              run;
    logic              wr_go;
    logic [IDX_W-1:0]  rd_idx   [NRD];
    logic              rd_half  [NRD];
    logic [DATA_W-1:0] rd_nib   [NRD];
    logic [DATA_W-1:0] port_out [NRD];
    logic              hit      [NRD];
    logic              reg_en   [NRD];

    nibram_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .capture (capture),
        .run     (run)
    );

    // Writes only once the block runs.
    assign wr_go = a_we & run;

    // Per-port address, half and hit selection.
    always_comb begin
        rd_idx[0]  = {cfg_q.page, a_addr};
        rd_idx[1]  = {cfg_q.page, b_addr};
        rd_half[0] = a_half;
        rd_half[1] = b_half;
        hit[0]     = wr_go;
        hit[1]     = wr_go && (b_addr == a_addr) && (b_half == a_half);
        reg_en[0]  = cfg_q.reg_a;
        reg_en[1]  = cfg_q.reg_b;
    end

    nibram_store #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W),
        .HALVES  (HALVES),
        .NRD     (NRD)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_go),
        .wr_idx  ({cfg_q.page, a_addr}),
        .wr_half (a_half),
        .wr_data (a_wdata),
        .rd_idx  (rd_idx),
        .rd_half (rd_half),
        .rd_data (rd_nib)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        nibram_rdport #(.DATA_W(DATA_W)) u_rd (
            .clk      (clk),
            .live     (run),
            .reg_en   (reg_en[p]),
            .fwd_en   (cfg_q.fwd),
            .hit      (hit[p]),
            .wr_data  (a_wdata),
            .mem_data (rd_nib[p]),
            .rdata    (port_out[p])
        );
    end

    assign a_rdata = port_out[0];
    assign b_rdata = port_out[1];
endmodule

// File: rtl/nibram_chk.sv
// Property checker for nibram_top, attached by bind below.
module nibram_chk
    import nibram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              capture,
    input cfg_t              cfg,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_half,
    input logic [DATA_W-1:0] a_wdata,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_half,
    input logic [DATA_W-1:0] a_rdata,
    input logic [DATA_W-1:0] b_rdata
);
    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(cfg));

    // R6
    rega_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (!cfg.reg_a || a_rdata == '0));

    // R8
    fwd_comb_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && a_we && cfg.fwd && !cfg.reg_a) |-> (a_rdata == a_wdata));

    // R9
    fwd_comb_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && a_we && cfg.fwd && !cfg.reg_b && b_addr == a_addr && b_half == a_half)
        |-> (b_rdata == a_wdata));

    // R10
    fwd_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && a_we && cfg.fwd && cfg.reg_a) |=> (a_rdata == $past(a_wdata)));
endmodule

bind nibram_top nibram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .capture (capture),
    .cfg     (cfg_q),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_half  (a_half),
    .a_wdata (a_wdata),
    .b_addr  (b_addr),
    .b_half  (b_half),
    .a_rdata (a_rdata),
    .b_rdata (b_rdata)
);

// File: tb/test_nibram_top.sv
`timescale 1ns/1ps
module test_nibram_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_in = 8'h00;
    logic [3:0] a_addr = '0;
    logic       a_half = 1'b0;
    logic       a_we = 1'b0;
    logic [3:0] a_wdata = '0;
    logic [3:0] b_addr = '0;
    logic       b_half = 1'b0;
    logic [3:0] a_rdata;
    logic [3:0] b_rdata;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    nibram_top i_nibram_top (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
        .a_addr(a_addr), .a_half(a_half), .a_we(a_we), .a_wdata(a_wdata),
        .b_addr(b_addr), .b_half(b_half),
        .a_rdata(a_rdata), .b_rdata(b_rdata)
    );

    typedef struct packed {
        logic [3:0] aa; logic ah; logic [3:0] wd; logic we;
        logic [3:0] ba; logic bh; logic [3:0] ea; logic [3:0] eb;
        logic ca; logic cb;
    } vec_t;

    // Option set 0: page 0, combinational, read-before-write (R2, R3, R8, R9).
    localparam vec_t VECS [8] = '{
        '{4'd3, 1'b0, 4'h5, 1'b1, 4'd3, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0},
        '{4'd3, 1'b1, 4'hA, 1'b1, 4'd3, 1'b0, 4'h0, 4'h5, 1'b0, 1'b1},
        '{4'd7, 1'b0, 4'hC, 1'b1, 4'd3, 1'b1, 4'h0, 4'hA, 1'b0, 1'b1},
        '{4'd3, 1'b0, 4'h0, 1'b0, 4'd7, 1'b0, 4'h5, 4'hC, 1'b1, 1'b1},
        '{4'd3, 1'b0, 4'h9, 1'b1, 4'd3, 1'b0, 4'h5, 4'h5, 1'b1, 1'b1},
        '{4'd3, 1'b0, 4'h0, 1'b0, 4'd3, 1'b1, 4'h9, 4'hA, 1'b1, 1'b1},
        '{4'd7, 1'b1, 4'h3, 1'b1, 4'd7, 1'b0, 4'h0, 4'hC, 1'b0, 1'b1},
        '{4'd7, 1'b1, 4'h0, 1'b0, 4'd7, 1'b0, 4'h3, 4'hC, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reset pulse with a chosen option byte; optional write held through release.
    task automatic rst_cfg(input logic [7:0] v, input logic wr_hold);
        @(negedge clk);
        rst_n = 1'b0; cfg_in = v; a_we = wr_hold;
        a_addr = 4'd3; a_half = 1'b0; a_wdata = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        cfg_in = ~v; a_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog act=%h exp=%h", 4'h0, 4'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_cfg(8'h00, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            a_addr = VECS[i].aa; a_half = VECS[i].ah; a_wdata = VECS[i].wd; a_we = VECS[i].we;
            b_addr = VECS[i].ba; b_half = VECS[i].bh;
            #1;
            if (VECS[i].ca) chk($sformatf("R2 R3 R8 table row %0d port A", i), a_rdata, VECS[i].ea);
            if (VECS[i].cb) chk($sformatf("R2 R3 R9 table row %0d port B", i), b_rdata, VECS[i].eb);
        end
        @(negedge clk); a_we = 1'b0;

        // R1: page 1 is separate storage
        rst_cfg(8'h01, 1'b0);
        a_addr = 4'd3; a_half = 1'b0; a_wdata = 4'h6; a_we = 1'b1;
        @(negedge clk); a_we = 1'b0; #1;
        chk("R1 page1 write readback", a_rdata, 4'h6);

        // R4, R5: write held through reset ignored, ignored option bits
        rst_cfg(8'h8E, 1'b1);
        #1 chk("R4 R5 R1 page0 kept, reset write dropped", a_rdata, 4'h9);
        a_addr = 4'd7; a_half = 1'b1; a_wdata = 4'h5; a_we = 1'b1;
        #1 chk("R5 R8 ignored bits keep read-before-write", a_rdata, 4'h3);
        @(negedge clk); a_we = 1'b0; #1;
        chk("R3 R5 high nibble written", a_rdata, 4'h5);

        // R4: contents survive reset
        rst_cfg(8'h01, 1'b0);
        #1 chk("R4 page1 survives reset", a_rdata, 4'h6);

        // R6, R10: registered port A
        rst_cfg(8'h10, 1'b0);
        #1 chk("R6 reset clears registered A", a_rdata, 4'h0);
        b_addr = 4'd3; b_half = 1'b1;
        #1 chk("R2 port B combinational", b_rdata, 4'hA);
        @(posedge clk); #1 chk("R6 one-cycle latency", a_rdata, 4'h9);
        @(negedge clk); a_addr = 4'd7; a_half = 1'b1;
        #1 chk("R6 output holds", a_rdata, 4'h9);
        @(posedge clk); #1 chk("R6 new address after edge", a_rdata, 4'h5);
        @(negedge clk); a_addr = 4'd3; a_half = 1'b0; a_wdata = 4'h1; a_we = 1'b1;
        @(posedge clk); #1 chk("R10 registered read-before-write", a_rdata, 4'h9);
        @(negedge clk); a_we = 1'b0;
        @(posedge clk); #1 chk("R10 new value next edge", a_rdata, 4'h1);

        // R10: registered A with forwarding
        rst_cfg(8'h50, 1'b0);
        a_addr = 4'd3; a_half = 1'b0; a_wdata = 4'h2; a_we = 1'b1;
        @(posedge clk); #1 chk("R10 registered forward", a_rdata, 4'h2);
        a_we = 1'b0;

        // R8, R9: combinational forwarding
        rst_cfg(8'h40, 1'b0);
        a_addr = 4'd7; a_half = 1'b0; a_wdata = 4'h4; a_we = 1'b1;
        b_addr = 4'd7; b_half = 1'b0;
        #1 chk("R8 port A forward", a_rdata, 4'h4);
        chk("R9 port B forward on match", b_rdata, 4'h4);
        b_half = 1'b1;
        #1 chk("R9 port B other nibble", b_rdata, 4'h5);
        @(negedge clk); a_we = 1'b0; #1;
        chk("R3 forwarded value stored", a_rdata, 4'h4);

        // R7: registered port B, read-before-write
        rst_cfg(8'h20, 1'b0);
        #1 chk("R7 reset clears registered B", b_rdata, 4'h0);
        a_addr = 4'd7; a_half = 1'b0; a_wdata = 4'h8; a_we = 1'b1;
        b_addr = 4'd7; b_half = 1'b0;
        @(posedge clk); #1 chk("R7 R10 registered B old value", b_rdata, 4'h4);
        a_we = 1'b0;
        @(posedge clk); #1 chk("R7 registered B new value", b_rdata, 4'h8);

        // R9, R10: registered B with forwarding
        rst_cfg(8'h60, 1'b0);
        a_addr = 4'd7; a_half = 1'b0; a_wdata = 4'hE; a_we = 1'b1;
        b_addr = 4'd7; b_half = 1'b0;
        #1 chk("R8 port A forward with B registered", a_rdata, 4'hE);
        @(posedge clk); #1 chk("R9 R10 registered B forward", b_rdata, 4'hE);
        a_we = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule